// File: doc/BRIEF.md
# Serial Register Access Port

This block gives an external host read and write access to a bank of 24-bit registers over a four-wire serial link. The host frames each transfer with an active-high enable and supplies a serial clock. A frame is 32 serial clock periods long. It carries a direction flag first, then a 6-bit register address, then 24 data bits. Every field is sent most significant bit first. The block samples incoming bits on rising serial clock edges. It presents read data so that the host can capture it on falling edges.

All serial inputs are brought into the block's own clock domain through synchronizer stages. Edge detection and frame decoding then run on the system clock, so the serial clock must be several times slower than the system clock. A write reaches the register bank only when the frame finishes on its 32nd falling edge. If enable drops earlier, the frame is discarded. The whole bank is also exposed as a flat vector for the surrounding chip logic.

Top module: `sreg_port`

## Requirements
- R1: After reset every register reads zero and `ser_out` is low.
- R2: A frame whose first bit is 0 is a write. The bit captured at rising edge 1 is the flag. Rising edges 2 to 7 carry the address MSB first, and rising edges 8 to 31 carry the 24 data bits MSB first. The addressed register takes the data after the 32nd falling edge.
- R3: If enable drops before the 32nd falling edge, the frame writes nothing.
- R4: A frame whose first bit is 1 is a read. `ser_out` shows data bit 23 down to bit 0 of the addressed register, so that the host samples them at falling edges 8 to 31.
- R5: `ser_out` stays low while enable is low and throughout every write frame.
- R6: An address at or above `NUM_REGS` (default 48) is discarded on a write and reads back as all zeros.
- R7: The bit counters return to zero whenever enable is low, so a frame that follows an aborted one decodes from its own first bit.
- R8: Serial clocks beyond the 32nd, while enable stays high, cause no second write and leave the committed value unchanged.
- R9: A write changes only the addressed register.
- R10: A read frame leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_en | input | 1 | Active-high frame enable from the host |
| ser_in | input | 1 | Serial data from the host |
| ser_out | output | 1 | Serial read data to the host |
| bank_q | output | NUM_REGS*DATA_W | All registers, register i at bits i*DATA_W upward |

## Verification
The assertions assume three things about the host. It holds every input steady for more than the synchronizer latency plus one cycle around each serial clock edge. It raises enable before the first rising edge. It drops enable in the same instant as the final falling edge, never earlier. The stimulus task drives all three host lines on system clock falling edges. It uses a serial half-period of eight system clocks and changes data only while the serial clock is low. It lowers enable together with the last falling edge, whether the frame is complete, aborted or extended. The per-register and single-commit checks therefore see clean, aligned edges in the synchronized domain.

// File: rtl/srp_pkg.sv
package srp_pkg;

   // Role of the bit captured on a given rising serial edge (edges count from 1)
   typedef enum logic [2:0] {
      PH_NONE,
      PH_FLAG,
      PH_ADDR,
      PH_DATA,
      PH_TAIL
   } bit_ph_e;

   function automatic bit_ph_e edge_phase(input int k, input int aw, input int dw);
      if (k == 1)                  return PH_FLAG;
      else if (k >= 2 && k <= 1 + aw)   return PH_ADDR;
      else if (k > 1 + aw && k <= 1 + aw + dw) return PH_DATA;
      else if (k == 2 + aw + dw)   return PH_TAIL;
      else                         return PH_NONE;
   endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES == 0) begin : g_thru
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) st[s] <= '0;
         end else begin
            st[0] <= d;
            for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
         end
      end
      assign q = st[STAGES-1];
   end

endmodule

// File: rtl/srp_frame.sv
module srp_frame
   import srp_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 24,
   localparam int FRAME_LEN = ADDR_W + DATA_W + 2,
   localparam int CNT_W     = $clog2(FRAME_LEN + 1),
   localparam int ADDR_LAST = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_clk,
   input  logic              s_en,
   input  logic              s_di,
   output logic              fall_o,
   output logic [CNT_W-1:0]  rcnt_o,
   output logic [CNT_W-1:0]  fcnt_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              wr_stb_o,
   output logic              rd_load_o
);

   logic              clk_d;
   logic              rise;
   logic              rw;
   logic [CNT_W-1:0]  rcnt;
   logic [CNT_W-1:0]  fcnt;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata;
   logic              wr_stb;
   logic              rd_load;
   int                k_next;

   assign rise   = s_clk & ~clk_d;
   assign fall_o = ~s_clk & clk_d;
   assign k_next = int'(rcnt) + 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_d   <= 1'b0;
         rw      <= 1'b0;
         rcnt    <= '0;
         fcnt    <= '0;
         addr    <= '0;
         wdata   <= '0;
         wr_stb  <= 1'b0;
         rd_load <= 1'b0;
      end else begin
         clk_d   <= s_clk;
         wr_stb  <= 1'b0;
         rd_load <= 1'b0;
         // The final falling edge arrives together with enable dropping
         if (fall_o && fcnt == CNT_W'(FRAME_LEN - 1) &&
             rcnt == CNT_W'(FRAME_LEN) && !rw)
            wr_stb <= 1'b1;
         if (!s_en) begin
            rcnt <= '0;
            fcnt <= '0;
         end else begin
            if (rise && rcnt < CNT_W'(FRAME_LEN)) begin
               rcnt <= rcnt + 1'b1;
               unique case (edge_phase(k_next, ADDR_W, DATA_W))
                  PH_FLAG: rw <= s_di;
                  PH_ADDR: begin
                     addr <= {addr[ADDR_W-2:0], s_di};
                     if (k_next == ADDR_LAST) rd_load <= rw;
                  end
                  PH_DATA: wdata <= {wdata[DATA_W-2:0], s_di};
                  default: ;
               endcase
            end
            if (fall_o && fcnt < CNT_W'(FRAME_LEN))
               fcnt <= fcnt + 1'b1;
         end
      end
   end

   assign rcnt_o    = rcnt;
   assign fcnt_o    = fcnt;
   assign addr_o    = addr;
   assign wdata_o   = wdata;
   assign wr_stb_o  = wr_stb;
   assign rd_load_o = rd_load;

endmodule

// File: rtl/srp_bank.sv
module srp_bank #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 24,
   parameter int NUM_REGS = 48
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_stb,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_REGS*DATA_W-1:0] bank_o
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_stb && addr == ADDR_W'(i))
            q <= wdata;
      end
      assign bank_o[i*DATA_W +: DATA_W] = q;
   end

   // Addresses past the last register match no entry and read as zero
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (addr == ADDR_W'(i)) rdata = bank_o[i*DATA_W +: DATA_W];
   end

endmodule

// File: rtl/srp_shout.sv
module srp_shout #(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 24,
   parameter bit IDLE_HIGHZ = 1'b0,
   localparam int FRAME_LEN  = ADDR_W + DATA_W + 2,
   localparam int CNT_W      = $clog2(FRAME_LEN + 1),
   localparam int SHIFT_FROM = ADDR_W + 1,
   localparam int SHIFT_TO   = ADDR_W + DATA_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_en,
   input  logic             fall,
   input  logic [CNT_W-1:0] fcnt,
   input  logic             rd_load,
   input  logic [DATA_W-1:0] rdata,
   output logic             ser_out
);

   logic              active;
   logic [DATA_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sh     <= '0;
      end else if (!s_en) begin
         active <= 1'b0;
      end else if (rd_load) begin
         active <= 1'b1;
         sh     <= rdata;
      end else if (active && fall &&
                   fcnt >= CNT_W'(SHIFT_FROM) && fcnt <= CNT_W'(SHIFT_TO)) begin
         sh <= {sh[DATA_W-2:0], 1'b0};
      end
   end

   if (IDLE_HIGHZ) begin : g_tri
      assign ser_out = active ? sh[DATA_W-1] : 1'bz;
   end else begin : g_low
      assign ser_out = active & sh[DATA_W-1];
   end

endmodule

// File: rtl/sreg_port.sv
module sreg_port #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 24,
   parameter int NUM_REGS    = 48,
   parameter int SYNC_STAGES = 2,
   parameter bit IDLE_HIGHZ  = 1'b0,
   localparam int FRAME_LEN = ADDR_W + DATA_W + 2,
   localparam int CNT_W     = $clog2(FRAME_LEN + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ser_clk,
   input  logic                       ser_en,
   input  logic                       ser_in,
   output logic                       ser_out,
   output logic [NUM_REGS*DATA_W-1:0] bank_q
);

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_aw
      $error("sreg_port: ADDR_W out of range");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("sreg_port: DATA_W too small");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_nr
      $error("sreg_port: NUM_REGS must fit the address space");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("sreg_port: SYNC_STAGES out of range");
   end

   logic              s_clk, s_en, s_di;
   logic              fall;
   logic [CNT_W-1:0]  rcnt, fcnt;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata, rdata;
   logic              wr_stb, rd_load;

   srp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk, ser_en, ser_in}),
      .q     ({s_clk, s_en, s_di})
   );

   srp_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_clk     (s_clk),
      .s_en      (s_en),
      .s_di      (s_di),
      .fall_o    (fall),
      .rcnt_o    (rcnt),
      .fcnt_o    (fcnt),
      .addr_o    (addr),
      .wdata_o   (wdata),
      .wr_stb_o  (wr_stb),
      .rd_load_o (rd_load)
   );

   srp_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata),
      .bank_o (bank_q)
   );

   srp_shout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDLE_HIGHZ(IDLE_HIGHZ)) u_shout (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_en    (s_en),
      .fall    (fall),
      .fcnt    (fcnt),
      .rd_load (rd_load),
      .rdata   (rdata),
      .ser_out (ser_out)
   );

endmodule

// File: rtl/srp_chk.sv
module srp_chk #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 24,
   parameter int NUM_REGS = 48,
   parameter int CNT_W    = 6
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       s_en,
   input logic                       ser_out,
   input logic                       wr_stb,
   input logic [ADDR_W-1:0]          waddr,
   input logic [DATA_W-1:0]          wdata,
   input logic [NUM_REGS*DATA_W-1:0] bank_q,
   input logic                       rd_load,
   input logic [DATA_W-1:0]          rdata,
   input logic [CNT_W-1:0]           rcnt,
   input logic [CNT_W-1:0]           fcnt
);

   logic s_en_d;
   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_en_d <= 1'b0;
         seen   <= 1'b0;
      end else begin
         s_en_d <= s_en;
         if (s_en && !s_en_d) seen <= 1'b0;
         else if (wr_stb)     seen <= 1'b1;
      end
   end

   AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && int'(waddr) < NUM_REGS) |=>
         (bank_q[int'($past(waddr))*DATA_W +: DATA_W] == $past(wdata))); // R2

   AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(bank_q)); // R10

   AST_OOR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && int'(waddr) >= NUM_REGS) |=> $stable(bank_q)); // R6

   AST_RD_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load |=> (ser_out === $past(rdata[DATA_W-1]))); // R4

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !s_en |=> (ser_out !== 1'b1)); // R5

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !s_en |=> (rcnt == '0 && fcnt == '0)); // R7

   AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !seen); // R8

endmodule

bind sreg_port srp_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS),
   .CNT_W    (CNT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_en    (s_en),
   .ser_out (ser_out),
   .wr_stb  (wr_stb),
   .waddr   (addr),
   .wdata   (wdata),
   .bank_q  (bank_q),
   .rd_load (rd_load),
   .rdata   (rdata),
   .rcnt    (rcnt),
   .fcnt    (fcnt)
);

// File: tb/sim_sreg_port.sv
module sim_sreg_port;

   localparam int AW   = 6;
   localparam int DW   = 24;
   localparam int NR   = 48;
   localparam int HALF = 8;
   localparam int FLEN = AW + DW + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_en = 1'b0;
   logic ser_in = 1'b0;
   logic ser_out;
   logic [NR*DW-1:0] bank_q;

   always #5 clk = ~clk;

   sreg_port #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .ser_clk (ser_clk),
      .ser_en  (ser_en),
      .ser_in  (ser_in),
      .ser_out (ser_out),
      .bank_q  (bank_q)
   );

   int     checks = 0;
   int     errors = 0;
   longint cyc = 0;
   longint skip_until = 0;
   bit     live = 1'b0;
   logic [DW-1:0] model [NR];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Reference: whole bank compared on every clock outside the commit window (R9, R10)
   always @(negedge clk) begin
      if (live && cyc >= skip_until) begin
         logic [NR*DW-1:0] e;
         for (int r = 0; r < NR; r++) e[r*DW +: DW] = model[r];
         checks++;
         if (bank_q !== e) begin
            errors++;
            $display("FAIL R9 bank contents actual=%h expected=%h", bank_q, e);
         end
      end
   end

   // rd: 1 read, 0 write. ncyc: serial clocks before enable drops.
   task automatic frame(input bit rd, input int a, input logic [DW-1:0] d,
                        input int ncyc, input string req);
      logic [DW-1:0] exp;
      logic [AW-1:0] av;
      bit b;
      av  = AW'(a);
      exp = (a < NR) ? model[a] : '0;
      tick(1);
      chk("R5", "idle ser_out", {{(DW-1){1'b0}}, ser_out}, '0);
      ser_en = 1'b1;
      tick(HALF);
      for (int i = 1; i <= ncyc; i++) begin
         if (i == 1)                b = rd;
         else if (i <= 1 + AW)      b = av[AW + 1 - i];
         else if (i <= 1 + AW + DW) b = d[AW + DW + 1 - i];
         else                       b = i[0];
         ser_in = b;
         tick(HALF);
         ser_clk = 1'b1;
         tick(HALF);
         if (i >= 2 + AW && i <= 1 + AW + DW) begin
            if (rd)
               chk(req, "read bit", {{(DW-1){1'b0}}, ser_out},
                   {{(DW-1){1'b0}}, exp[AW + DW + 1 - i]});
            else
               chk("R5", "ser_out during write", {{(DW-1){1'b0}}, ser_out}, '0);
         end
         ser_clk = 1'b0;
         if (i == FLEN && !rd && a < NR) begin
            skip_until = cyc + 12;
            model[a] = d;
         end
         if (i == ncyc) ser_en = 1'b0;
      end
      tick(HALF);
      ser_in = 1'b0;
   endtask

   initial begin
      for (int r = 0; r < NR; r++) model[r] = '0;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      // R1: reset state
      chk("R1", "ser_out after reset", {{(DW-1){1'b0}}, ser_out}, '0);
      checks++;
      if (bank_q !== '0) begin
         errors++;
         $display("FAIL R1 bank after reset actual=%h expected=0", bank_q);
      end
      live = 1'b1;

      // R2 R4: plain write then read
      frame(1'b0, 5, 24'hA5A5A5, FLEN, "R2");
      frame(1'b1, 5, '0, FLEN, "R4");
      // R2 boundaries of the address range and of the data
      frame(1'b0, 0, 24'hFFFFFF, FLEN, "R2");
      frame(1'b0, NR - 1, 24'h000001, FLEN, "R2");
      frame(1'b1, 0, '0, FLEN, "R4");
      frame(1'b1, NR - 1, '0, FLEN, "R4");
      // R3: aborted writes at several points, R7: next frame decodes cleanly
      frame(1'b0, 5, 24'h123456, 20, "R3");
      frame(1'b0, 5, 24'h654321, FLEN - 1, "R3");
      frame(1'b0, 5, 24'h777777, 1, "R3");
      frame(1'b1, 5, '0, FLEN, "R3");
      frame(1'b0, 9, 24'h5A5A5A, FLEN, "R7");
      frame(1'b1, 9, '0, FLEN, "R7");
      // R3: aborted read, then read again
      frame(1'b1, 9, '0, 15, "R3");
      frame(1'b1, 9, '0, FLEN, "R7");
      // R6: outside the implemented bank
      frame(1'b0, 50, 24'hDEADBE, FLEN, "R6");
      frame(1'b1, 50, '0, FLEN, "R6");
      frame(1'b1, 63, '0, FLEN, "R6");
      // R8: extended frame, extra edges carry other bits
      frame(1'b0, 17, 24'h800000, FLEN + 8, "R8");
      frame(1'b1, 17, '0, FLEN, "R8");
      // R10: back-to-back reads leave everything untouched
      frame(1'b1, 0, '0, FLEN, "R10");
      frame(1'b1, 0, '0, FLEN, "R10");
      // R9: a spread of addresses and data patterns
      for (int k = 0; k < 12; k++) begin
         int a;
         logic [DW-1:0] d;
         a = (k * 7 + 3) % NR;
         d = DW'(k * 24'h13579B) ^ 24'h2468AC;
         frame(1'b0, a, d, FLEN, "R9");
         frame(1'b1, a, '0, FLEN, "R9");
      end
      frame(1'b1, 5, '0, FLEN, "R9");
      tick(20);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule